// File: doc/BRIEF.md
# PHY Control-Register Bus Master

This block gives a host simple read and write access to the internal 16-bit registers of a serial PHY. The PHY exposes these registers through a narrow control bus. A single 16-bit input bus carries first an address and then, for writes, the data. Four strobes tell the PHY what to do with the value on that bus: capture it as an address, capture it as data, perform a read, or perform a write. The PHY answers every strobe on one acknowledge line and presents read results on a 16-bit output bus.

The host offers a command on a valid/ready interface. A command holds a direction flag, an address and, for writes, the data. The sequencer breaks each command into a chain of four-phase handshakes. For every strobe it raises the strobe, waits for the acknowledge to rise, lowers the strobe, and then waits for the acknowledge to fall. Each wait is bounded by a timeout counted in clock cycles. When a wait expires, the chain moves on and a sticky error flag is raised for that command. When the chain ends, a one-cycle done pulse returns the read data and the error flag.

The PHY-side pins are packed into a 20-bit control word and a 17-bit status word, so that the PHY glue logic can decode them at fixed positions.

Top module: `phy_cr_master`

## Requirements
- R1: After reset, every strobe is low, the data-in field is zero, `cmd_ready` is high and `rsp_done` is low.
- R2: The control word places the write strobe at bit 0, the read strobe at bit 1, data-in at bits 17:2, the capture-data strobe at bit 18 and the capture-address strobe at bit 19. The status word supplies data-out at bits 15:0 and acknowledge at bit 16.
- R3: Every command begins with a capture-address handshake. The address is already on data-in one cycle before that strobe rises, and it stays there while the strobe is high.
- R4: For each strobe, the strobe stays high until the synchronized acknowledge is high. The next strobe does not rise until the acknowledge is low again. The acknowledge passes through two flops: the strobe falls on the third clock edge after the acknowledge rises.
- R5: A read runs the address handshake and then a read-strobe handshake. Data-out is sampled while the acknowledge is high, and that value is returned in `rsp_rdata` with the done pulse.
- R6: A write runs the address handshake, then a capture-data handshake with the write data on data-in, then a separate write-strobe handshake.
- R7: At most one of the four strobes is high in any cycle.
- R8: A wait for the acknowledge to rise keeps the strobe high for exactly TIMEOUT_CYC cycles when no acknowledge arrives. After any wait expires, the sequence goes on to its next step.
- R9: `rsp_err` is high with the done pulse if any wait in that command expired. The flag is cleared when the next command is accepted.
- R10: `rsp_rdata` is zero on completion of a write, and zero on completion of a read whose read-strobe acknowledge never arrived.
- R11: `cmd_ready` is high only while the sequencer is idle, and it falls in the cycle after a command is accepted. `rsp_done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle; the command is taken on valid and ready |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| rsp_err | output | 1 | A wait expired during the command |
| phy_ctrl | output | 20 | Packed strobes and data-in to the PHY |
| phy_stat | input | 17 | Packed data-out and acknowledge from the PHY |

## Verification
A behavioural PHY model answers the strobes and takes four personalities.

- **Fast and slow responder:** The normal responder answers quickly in some runs and slowly in others. Comparing the two shows that the sequencer waits on the acknowledge rather than on a fixed delay.
- **Silent responder:** This PHY never acknowledges. It exposes the rise timeout, the exact strobe-high window, the zero read result and the error flag.
- **Stuck responder:** This PHY raises the acknowledge and never releases it. It exercises the fall timeout, while showing that the read data sampled during the high phase is still returned.

Write-then-read-back pairs at different addresses check three things: address capture, data capture and the order of the phases. Returning to the normal responder after each fault shows that the error flag clears.

// File: rtl/cr_pkg.sv
package cr_pkg;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ASSERT,
    ST_RELEASE,
    ST_FINISH
  } cr_state_e;

  // Handshake phase within one command
  typedef enum logic [1:0] {
    PH_ADDR,
    PH_RDSTB,
    PH_DATA,
    PH_WRSTB
  } cr_phase_e;

  // Strobe vector index: 0 write, 1 read, 2 capture-data, 3 capture-address
  localparam int unsigned STB_WR   = 0;
  localparam int unsigned STB_RD   = 1;
  localparam int unsigned STB_CAPD = 2;
  localparam int unsigned STB_CAPA = 3;
  localparam int unsigned STB_N    = 4;

  function automatic logic [STB_N-1:0] phase_strobe(cr_phase_e ph);
    logic [STB_N-1:0] s;
    s = '0;
    case (ph)
      PH_ADDR:  s[STB_CAPA] = 1'b1;
      PH_DATA:  s[STB_CAPD] = 1'b1;
      PH_RDSTB: s[STB_RD]   = 1'b1;
      PH_WRSTB: s[STB_WR]   = 1'b1;
      default:  s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cr_ack_sync.sv
module cr_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

  generate
    if (STAGES == 2) begin : g_two_stage_chk
      // R4
      sync_lag_chk: assert property (@(posedge clk) disable iff (rst)
        q |-> $past(d, 2));
    end
  endgenerate

endmodule

// File: rtl/cr_wait_timer.sv
module cr_wait_timer #(
  parameter int unsigned LIMIT = 100_000_000,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (cnt != CW'(LIMIT - 1)) cnt <= cnt + CW'(1);
  end

  assign expired = run && (cnt == CW'(LIMIT - 1));

  // R8
  tmo_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && !expired) |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/cr_hs_fsm.sv
module cr_hs_fsm
  import cr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  input  logic              ack_s,
  input  logic [DATA_W-1:0] phy_dout,
  input  logic              tmo_expired,
  output logic              tmo_run,
  output logic              tmo_restart,
  output logic [STB_N-1:0]  strb_q,
  output logic [DATA_W-1:0] bus_q,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  cr_state_e         st_q, st_n;
  cr_phase_e         ph_q, ph_n;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              accept;
  logic              tmo_hit;

  assign accept = cmd_valid && (st_q == ST_IDLE);

  always_comb begin
    st_n = st_q;
    ph_n = ph_q;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          st_n = ST_SETUP;
          ph_n = PH_ADDR;
        end
      end
      ST_SETUP:  st_n = ST_ASSERT;
      ST_ASSERT: begin
        if (ack_s || tmo_expired) st_n = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (!ack_s || tmo_expired) begin
          case (ph_q)
            PH_ADDR: begin
              st_n = ST_SETUP;
              ph_n = wr_q ? PH_DATA : PH_RDSTB;
            end
            PH_DATA: begin
              st_n = ST_SETUP;
              ph_n = PH_WRSTB;
            end
            default: st_n = ST_FINISH;
          endcase
        end
      end
      ST_FINISH: st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  assign tmo_hit = ((st_q == ST_ASSERT) && !ack_s && tmo_expired) ||
                   ((st_q == ST_RELEASE) && ack_s && tmo_expired);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_ADDR;
      strb_q  <= '0;
      bus_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      strb_q <= (st_n == ST_ASSERT) ? phase_strobe(ph_n) : '0;
      if (accept) begin
        wr_q    <= cmd_write;
        wdata_q <= cmd_wdata;
        bus_q   <= cmd_addr;
        rdata_q <= '0;
        err_q   <= 1'b0;
      end else begin
        if (st_q == ST_RELEASE && st_n == ST_SETUP && ph_n == PH_DATA)
          bus_q <= wdata_q;
        if (st_q == ST_ASSERT && ack_s && ph_q == PH_RDSTB)
          rdata_q <= phy_dout;
        if (tmo_hit)
          err_q <= 1'b1;
      end
    end
  end

  assign cmd_ready   = (st_q == ST_IDLE);
  assign rsp_done    = (st_q == ST_FINISH);
  assign rsp_rdata   = rdata_q;
  assign rsp_err     = err_q;
  assign tmo_run     = (st_q == ST_ASSERT) || (st_q == ST_RELEASE);
  assign tmo_restart = (st_n != st_q);

  // R7
  strb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb_q));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (strb_q == '0));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !rsp_err);

  // R4
  strobe_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(|strb_q) |-> $past(ack_s || tmo_expired));

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import cr_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned TIMEOUT_CYC = 100_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CTRL_W     = DATA_W + 4,
  localparam int unsigned STAT_W     = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [CTRL_W-1:0] phy_ctrl,
  input  logic [STAT_W-1:0] phy_stat
);

  logic              ack_s;
  logic              tmo_run;
  logic              tmo_restart;
  logic              tmo_expired;
  logic [STB_N-1:0]  strb;
  logic [DATA_W-1:0] bus;

  cr_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (phy_stat[DATA_W]),
    .q   (ack_s)
  );

  cr_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (tmo_run),
    .restart (tmo_restart),
    .expired (tmo_expired)
  );

  cr_hs_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .cmd_ready   (cmd_ready),
    .ack_s       (ack_s),
    .phy_dout    (phy_stat[DATA_W-1:0]),
    .tmo_expired (tmo_expired),
    .tmo_run     (tmo_run),
    .tmo_restart (tmo_restart),
    .strb_q      (strb),
    .bus_q       (bus),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err)
  );

  // Control word layout: [0] write, [1] read, [DATA_W+1:2] data-in,
  // [DATA_W+2] capture-data, [DATA_W+3] capture-address
  assign phy_ctrl = {strb[STB_CAPA], strb[STB_CAPD], bus, strb[STB_RD], strb[STB_WR]};

endmodule

// File: tb/phy_cr_master_tb.sv
module phy_cr_master_tb;

  localparam int TMO = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  logic        ack_m = 1'b0;
  logic [15:0] dout_m = '0;
  assign phy_stat = {ack_m, dout_m};

  always #5 clk = ~clk;

  phy_cr_master #(.DATA_W(16), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input int i);
    return 16'((i * 16'h0101) ^ 16'h5A3C);
  endfunction

  // PHY model modes: 0 normal, 1 silent, 2 stuck acknowledge
  int          mode = 0;
  int          lat = 1;
  logic [15:0] mem [256];
  logic [15:0] ref_mem [256];
  logic [15:0] a_reg = '0, d_reg = '0;
  logic [15:0] exp_addr = '0, exp_wdata = '0;
  logic [3:0]  strb_p = '0;
  logic [15:0] bus_p = '0;
  int          wc = 0, hi_len = 0, dl = 0;
  bit          trk = 0, done_p = 0;
  int          viol_oh = 0, viol_hs = 0;
  string       ev = "";

  // Scoreboard queues
  logic [15:0] q_rd  [$];
  logic        q_err [$];
  string       q_ev  [$];

  wire [3:0]  strb = {phy_ctrl[19], phy_ctrl[18], phy_ctrl[1], phy_ctrl[0]};
  wire [15:0] bus  = phy_ctrl[17:2];

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = init_val(i);
      ref_mem[i] = init_val(i);
    end
  end

  always @(negedge clk) begin
    logic [3:0] rise, fall;
    if (!rst) begin
      rise = strb & ~strb_p;
      fall = strb_p & ~strb;
      if ($countones(strb) > 1) viol_oh++;
      if (mode == 0 && |fall && !ack_m) viol_hs++;
      if (mode == 0 && |rise && ack_m) viol_hs++;
      if (|strb) hi_len++;
      if (|fall) begin
        if (mode == 1) chk(hi_len == TMO, "R8 strobe window", hi_len, TMO);
        hi_len = 0;
      end
      if (trk) begin
        if (|strb) dl++;
        else begin
          chk(dl == 2, "R4 sync latency", dl, 2);
          trk = 0;
        end
      end
      if (rise[3]) begin
        chk(bus == exp_addr, "R3 address on bus", bus, exp_addr);
        chk(bus_p == exp_addr, "R3 address setup", bus_p, exp_addr);
        ev = {ev, "A"};
        if (mode != 1) a_reg = bus;
      end
      if (rise[2]) begin
        chk(bus == exp_wdata, "R6 data on bus", bus, exp_wdata);
        ev = {ev, "D"};
        if (mode != 1) d_reg = bus;
      end
      if (rise[1]) begin
        ev = {ev, "R"};
        if (mode != 1) dout_m = mem[a_reg[7:0]];
      end
      if (rise[0]) begin
        ev = {ev, "W"};
        if (mode != 1) mem[a_reg[7:0]] = d_reg;
      end
      if (mode != 1) begin
        if (|strb && !ack_m) begin
          if (wc >= lat) begin ack_m = 1'b1; wc = 0; trk = (mode == 0); dl = 0; end
          else wc++;
        end else if (!(|strb) && ack_m && mode != 2) begin
          if (wc >= lat) begin ack_m = 1'b0; wc = 0; end
          else wc++;
        end else wc = 0;
      end
      // monitor
      if (done_p) chk(!rsp_done, "R11 done one cycle", rsp_done, 0);
      done_p = rsp_done;
      if (rsp_done) begin
        if (q_rd.size() == 0) chk(0, "R11 unexpected done", 1, 0);
        else begin
          logic [15:0] e_rd;
          logic        e_err;
          string       e_ev;
          e_rd = q_rd.pop_front();
          e_err = q_err.pop_front();
          e_ev = q_ev.pop_front();
          chk(rsp_rdata == e_rd, "R5/R10 read data", rsp_rdata, e_rd);
          chk(rsp_err == e_err, "R9 error flag", rsp_err, e_err);
          checks++;
          if (ev != e_ev) begin
            errors++;
            $display("FAIL R5/R6 phase order actual=%s expected=%s", ev, e_ev);
          end
        end
        ev = "";
      end
      strb_p = strb;
      bus_p = bus;
    end
  end

  task automatic do_cmd(input bit wr, input logic [15:0] addr, input logic [15:0] data);
    bit e_err;
    e_err = (mode != 0);
    exp_addr = addr;
    exp_wdata = data;
    if (wr) begin
      q_rd.push_back(16'h0);
      q_ev.push_back("ADW");
      if (mode != 1) ref_mem[addr[7:0]] = data;
    end else begin
      q_rd.push_back(mode == 1 ? 16'h0 : ref_mem[addr[7:0]]);
      q_ev.push_back("AR");
    end
    q_err.push_back(e_err);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_addr = addr;
    cmd_wdata = data;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    chk(!cmd_ready, "R11 ready drops after accept", cmd_ready, 0);
    cmd_valid = 1'b0;
    cmd_addr = 16'hDEAD;
    cmd_wdata = 16'hDEAD;
    while (q_rd.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(phy_ctrl == 20'h0, "R1 control word in reset", phy_ctrl, 0);
    chk(cmd_ready == 1'b1, "R1 ready in reset", cmd_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(phy_ctrl == 20'h0, "R1 control word after reset", phy_ctrl, 0);
    chk(rsp_done == 1'b0, "R1 done low", rsp_done, 0);
    chk(cmd_ready == 1'b1, "R1 ready high", cmd_ready, 1);

    // R2 R5 R6 normal responder, fast
    lat = 1;
    do_cmd(1, 16'h0012, 16'hBEEF);
    do_cmd(0, 16'h0012, 16'h0);
    do_cmd(0, 16'h0034, 16'h0);
    // slow responder
    lat = 5;
    do_cmd(1, 16'h1256, 16'h0000);
    do_cmd(1, 16'h00FF, 16'hFFFF);
    do_cmd(0, 16'h00FF, 16'h0);
    do_cmd(0, 16'h1256, 16'h0);
    lat = 0;
    do_cmd(0, 16'h0012, 16'h0);

    // R8 R9 R10 silent responder
    mode = 1;
    do_cmd(0, 16'h0040, 16'h0);
    do_cmd(1, 16'h0041, 16'h1111);
    mode = 0;
    lat = 2;
    do_cmd(0, 16'h0041, 16'h0);

    // R8 R9 stuck acknowledge
    mode = 2;
    do_cmd(0, 16'h0012, 16'h0);
    do_cmd(1, 16'h0013, 16'h7777);
    mode = 0;
    repeat (10) @(negedge clk);
    do_cmd(0, 16'h0013, 16'h0);

    chk(viol_oh == 0, "R7 strobes one-hot", viol_oh, 0);
    chk(viol_hs == 0, "R4 handshake order", viol_hs, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule